// File: doc/BRIEF.md
# Thread Context Match Engine

This block decides which hardware thread should be signalled for an incoming event notification. The notification names a virtual target as a block number and an index. It also carries a format bit, an ignore flag and a logical server number. Each of the N threads holds interrupt context state for four privilege rings: physical hypervisor, pool hypervisor, OS and user. Every ring has its own valid bit and its own compare source. The physical ring compares a fixed chip/thread identifier. The pool and OS rings compare a stored target identifier. The user ring also requires the OS ring to match and the logical server number to be equal.

A request is accepted through a valid/ready handshake while the engine is idle. It then walks the threads from 0 to N-1, one per clock. Threads whose enable bit is clear are passed over. The engine finishes with a one-cycle `done` pulse and exactly one outcome: a single match (thread and ring), a duplicate error, an unsupported-request error, or an escalation request when no thread holds the target. The controller has three states. S_IDLE moves to S_SCAN when a supported request is accepted, or straight to S_DONE when an unsupported one is accepted. S_SCAN moves to S_DONE after the last thread has been examined. S_DONE always returns to S_IDLE.

Top module: `ipt_ctx_matcher`

## Requirements
- R1: The target identifier is {block, index}, with block in the upper bits and the 19-bit index below, so the value is (block << 19) | index. The pool ring and the OS ring match only when their valid bit is set and their stored identifier equals this value.
- R2: With BLOCK_GROUP=0, a thread's fixed physical CAM is chip_id<<11 | 1<<7 | thread_number, a 23-bit value. The value the notification offers is built the same way, using block[3:0] as the chip and index[6:0] as the thread. The physical ring matches when its valid bit is set and the two values are equal, so index bits above bit 6 do not take part.
- R3: With format 0 and the ignore flag clear, the rings of a thread are tried in the order physical, pool, OS, and the first hit is reported. Ring codes are 3=physical, 2=pool, 1=OS, 0=user.
- R4: With format 1, only the user ring is tried. It matches when the OS ring conditions hold, the user valid bit is set, and the stored logical server number equals the requested one.
- R5: Format 0 with the ignore flag set raises unsupported_error, with match_valid and escalate low. Its done pulse comes on the clock edge that accepts the request.
- R6: If more than one enabled thread matches, dup_error is raised and match_valid and escalate stay low.
- R7: If no enabled thread matches a supported request, escalate is raised and match_valid is low. At done, exactly one of match_valid, dup_error, unsupported_error and escalate is high.
- R8: A thread whose thread_en bit is 0 never matches.
- R9: For a supported request, done is high for exactly one cycle, starting N_THREADS clock edges after the edge that accepts the request. req_ready is high only in S_IDLE, and a request presented while the engine is busy is ignored.
- R10: The result outputs keep their values until the next request is accepted, even when the thread context inputs change.
- R11: After reset, req_ready is 1 and done, match_valid, dup_error, unsupported_error and escalate are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Notification request present |
| req_ready | output | 1 | Engine idle; a request is accepted on this edge |
| req_block | input | BLK_W | Target block number |
| req_index | input | IDX_W | Target index |
| req_format | input | 1 | 0 = specific target, 1 = user-level target |
| req_ignore | input | 1 | Logical-server request flag |
| req_lserv | input | LS_W | Requested logical server number |
| chip_id | input | 4 | Chip number used in the fixed physical CAM |
| thread_en | input | N_THREADS | Per-thread scan enable |
| ctx_phys_vld | input | N_THREADS | Physical ring valid bits |
| ctx_pool_vld | input | N_THREADS | Pool ring valid bits |
| ctx_pool_cam | input | N_THREADS*(BLK_W+IDX_W) | Pool ring target identifiers |
| ctx_os_vld | input | N_THREADS | OS ring valid bits |
| ctx_os_cam | input | N_THREADS*(BLK_W+IDX_W) | OS ring target identifiers |
| ctx_usr_vld | input | N_THREADS | User ring valid bits |
| ctx_usr_ls | input | N_THREADS*LS_W | User ring logical server numbers |
| done | output | 1 | One-cycle result strobe |
| match_valid | output | 1 | Exactly one thread matched |
| thread_id | output | $clog2(N_THREADS) | Matching thread |
| ring | output | 2 | Matching ring code |
| dup_error | output | 1 | More than one thread matched |
| unsupported_error | output | 1 | Logical-server request refused |
| escalate | output | 1 | Target is not dispatched on any thread |

## Verification
For a supported request, the result and done become visible N_THREADS clock edges after the accepting edge. For an unsupported request they become visible on the accepting edge itself. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the first one after acceptance until done appears, then compares that count with the latency due for the request kind (N_THREADS or 0) before it looks at the outcome fields. A further falling edge confirms that done has dropped. The timing test also samples the falling edges just before and just after the due edge, and checks that a request presented in mid-scan leaves the result unchanged.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    typedef enum logic [1:0] {
        RING_USER = 2'd0,
        RING_OS   = 2'd1,
        RING_POOL = 2'd2,
        RING_PHYS = 2'd3
    } ring_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SCAN = 2'd1,
        S_DONE = 2'd2
    } state_e;

    localparam int CHIP_W  = 4;
    localparam int HWTID_W = 7;
    localparam int HWCAM_W = 23;

endpackage

// File: rtl/ipt_cam_form.sv
module ipt_cam_form
    import ipt_pkg::*;
#(
    parameter bit BLOCK_GROUP = 1'b0
) (
    input  logic [CHIP_W-1:0]  chip,
    input  logic [HWTID_W-1:0] tid,
    output logic [HWCAM_W-1:0] cam
);

    generate
        if (BLOCK_GROUP) begin : g_grouped
            // marker bit at 11, chip in 10:7, thread in 6:0
            assign cam = {11'd0, 1'b1, chip, tid};
        end else begin : g_normal
            // chip in 14:11, marker bit at 7, thread in 6:0
            assign cam = {8'd0, chip, 3'd0, 1'b1, tid};
        end
    endgenerate

endmodule

// File: rtl/ipt_ring_match.sv
module ipt_ring_match
    import ipt_pkg::*;
#(
    parameter int ID_W = 23,
    parameter int LS_W = 8
) (
    input  logic               fmt,
    input  logic [ID_W-1:0]    req_id,
    input  logic [HWCAM_W-1:0] req_hwcam,
    input  logic [LS_W-1:0]    req_ls,
    input  logic [HWCAM_W-1:0] thr_hwcam,
    input  logic               phys_vld,
    input  logic               pool_vld,
    input  logic [ID_W-1:0]    pool_cam,
    input  logic               os_vld,
    input  logic [ID_W-1:0]    os_cam,
    input  logic               usr_vld,
    input  logic [LS_W-1:0]    usr_ls,
    output logic               hit,
    output ring_e              ring
);

    logic phys_hit, pool_hit, os_hit, usr_hit;

    assign phys_hit = phys_vld && (thr_hwcam == req_hwcam);
    assign pool_hit = pool_vld && (pool_cam == req_id);
    assign os_hit   = os_vld && (os_cam == req_id);
    assign usr_hit  = os_hit && usr_vld && (usr_ls == req_ls);

    always_comb begin
        hit  = 1'b0;
        ring = RING_USER;
        if (fmt) begin
            hit  = usr_hit;
            ring = RING_USER;
        end else if (phys_hit) begin
            hit  = 1'b1;
            ring = RING_PHYS;
        end else if (pool_hit) begin
            hit  = 1'b1;
            ring = RING_POOL;
        end else if (os_hit) begin
            hit  = 1'b1;
            ring = RING_OS;
        end
    end

endmodule

// File: rtl/ipt_ctx_matcher.sv
module ipt_ctx_matcher
    import ipt_pkg::*;
#(
    parameter int N_THREADS   = 8,
    parameter int BLK_W       = 4,
    parameter int IDX_W       = 19,
    parameter int LS_W        = 8,
    parameter bit BLOCK_GROUP = 1'b0,
    localparam int ID_W  = BLK_W + IDX_W,
    localparam int TID_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [BLK_W-1:0]          req_block,
    input  logic [IDX_W-1:0]          req_index,
    input  logic                      req_format,
    input  logic                      req_ignore,
    input  logic [LS_W-1:0]           req_lserv,
    input  logic [CHIP_W-1:0]         chip_id,
    input  logic [N_THREADS-1:0]      thread_en,
    input  logic [N_THREADS-1:0]      ctx_phys_vld,
    input  logic [N_THREADS-1:0]      ctx_pool_vld,
    input  logic [N_THREADS*ID_W-1:0] ctx_pool_cam,
    input  logic [N_THREADS-1:0]      ctx_os_vld,
    input  logic [N_THREADS*ID_W-1:0] ctx_os_cam,
    input  logic [N_THREADS-1:0]      ctx_usr_vld,
    input  logic [N_THREADS*LS_W-1:0] ctx_usr_ls,
    output logic                      done,
    output logic                      match_valid,
    output logic [TID_W-1:0]          thread_id,
    output logic [1:0]                ring,
    output logic                      dup_error,
    output logic                      unsupported_error,
    output logic                      escalate
);

    state_e state, nxt;

    // latched request
    logic [BLK_W-1:0] r_blk;
    logic [IDX_W-1:0] r_idx;
    logic             r_fmt;
    logic [LS_W-1:0]  r_ls;

    // scan position and running tally
    logic [TID_W-1:0] cnt;
    logic             acc_found, acc_dup;
    logic [TID_W-1:0] acc_tid;
    ring_e            acc_ring;

    // results held for the outputs
    logic             res_mv, res_dup, res_uns, res_esc;
    logic [TID_W-1:0] res_tid;
    ring_e            res_ring;

    logic [ID_W-1:0]    req_id;
    logic [HWCAM_W-1:0] req_hwcam;
    logic               accept, unsup_req, last;
    logic               cur_hit, fin_found, fin_dup;
    ring_e              cur_ring;

    logic  [N_THREADS-1:0] thr_hit;
    ring_e                 thr_ring [N_THREADS];

    assign req_id    = {r_blk, r_idx};
    assign accept    = req_valid && (state == S_IDLE);
    assign unsup_req = !req_format && req_ignore;
    assign last      = (cnt == TID_W'(N_THREADS - 1));

    ipt_cam_form #(.BLOCK_GROUP(BLOCK_GROUP)) u_req_cam (
        .chip (r_blk[CHIP_W-1:0]),
        .tid  (r_idx[HWTID_W-1:0]),
        .cam  (req_hwcam)
    );

    generate
        for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
            logic [HWCAM_W-1:0] hw_cam;

            ipt_cam_form #(.BLOCK_GROUP(BLOCK_GROUP)) u_thr_cam (
                .chip (chip_id),
                .tid  (HWTID_W'(t)),
                .cam  (hw_cam)
            );

            ipt_ring_match #(.ID_W(ID_W), .LS_W(LS_W)) u_match (
                .fmt       (r_fmt),
                .req_id    (req_id),
                .req_hwcam (req_hwcam),
                .req_ls    (r_ls),
                .thr_hwcam (hw_cam),
                .phys_vld  (ctx_phys_vld[t]),
                .pool_vld  (ctx_pool_vld[t]),
                .pool_cam  (ctx_pool_cam[t*ID_W +: ID_W]),
                .os_vld    (ctx_os_vld[t]),
                .os_cam    (ctx_os_cam[t*ID_W +: ID_W]),
                .usr_vld   (ctx_usr_vld[t]),
                .usr_ls    (ctx_usr_ls[t*LS_W +: LS_W]),
                .hit       (thr_hit[t]),
                .ring      (thr_ring[t])
            );
        end
    endgenerate

    always_comb begin
        cur_hit   = thread_en[cnt] && thr_hit[cnt];
        cur_ring  = thr_ring[cnt];
        fin_found = acc_found || cur_hit;
        fin_dup   = acc_dup || (acc_found && cur_hit);
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (accept) nxt = unsup_req ? S_DONE : S_SCAN;
            S_SCAN: if (last) nxt = S_DONE;
            S_DONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // request latch, scan tally and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_blk     <= '0;
            r_idx     <= '0;
            r_fmt     <= 1'b0;
            r_ls      <= '0;
            cnt       <= '0;
            acc_found <= 1'b0;
            acc_dup   <= 1'b0;
            acc_tid   <= '0;
            acc_ring  <= RING_USER;
            res_mv    <= 1'b0;
            res_dup   <= 1'b0;
            res_uns   <= 1'b0;
            res_esc   <= 1'b0;
            res_tid   <= '0;
            res_ring  <= RING_USER;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (accept) begin
                        r_blk     <= req_block;
                        r_idx     <= req_index;
                        r_fmt     <= req_format;
                        r_ls      <= req_lserv;
                        cnt       <= '0;
                        acc_found <= 1'b0;
                        acc_dup   <= 1'b0;
                        acc_tid   <= '0;
                        acc_ring  <= RING_USER;
                        res_mv    <= 1'b0;
                        res_dup   <= 1'b0;
                        res_esc   <= 1'b0;
                        res_tid   <= '0;
                        res_ring  <= RING_USER;
                        res_uns   <= unsup_req;
                    end
                end
                S_SCAN: begin
                    cnt <= cnt + TID_W'(1);
                    if (cur_hit) begin
                        if (acc_found) begin
                            acc_dup <= 1'b1;
                        end else begin
                            acc_found <= 1'b1;
                            acc_tid   <= cnt;
                            acc_ring  <= cur_ring;
                        end
                    end
                    if (last) begin
                        res_mv   <= fin_found && !fin_dup;
                        res_dup  <= fin_dup;
                        res_esc  <= !fin_found;
                        res_tid  <= acc_found ? acc_tid : (cur_hit ? cnt : '0);
                        res_ring <= acc_found ? acc_ring : (cur_hit ? cur_ring : RING_USER);
                    end
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready         = (state == S_IDLE);
        done              = (state == S_DONE);
        match_valid       = res_mv;
        dup_error         = res_dup;
        unsupported_error = res_uns;
        escalate          = res_esc;
        thread_id         = res_tid;
        ring              = res_ring;
    end

    // checks on the handshake and the result
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_scan_no_early_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !(!req_format && req_ignore)) |=> !done);

    assert_unsup_immediate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_format && req_ignore)
            |=> (done && unsupported_error && !match_valid && !escalate));

    assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({match_valid, dup_error, unsupported_error, escalate}) == 1));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> ($stable(match_valid) && $stable(thread_id) &&
            $stable(ring) && $stable(dup_error) && $stable(unsupported_error) &&
            $stable(escalate)));

endmodule

// File: tb/tb_ipt_ctx_matcher.sv
module tb_ipt_ctx_matcher;

    localparam int N     = 4;
    localparam int BLK_W = 4;
    localparam int IDX_W = 19;
    localparam int LS_W  = 8;
    localparam int ID_W  = BLK_W + IDX_W;
    localparam int TID_W = 2;

    typedef struct packed {
        logic [3:0]  blk;
        logic [18:0] idx;
        logic        fmt;
        logic        ign;
        logic [7:0]  ls;
        logic        mv;
        logic [1:0]  tid;
        logic [1:0]  rng;
        logic        dup;
        logic        uns;
        logic        esc;
    } vec_t;

    // fixed context: chip 5; see init_ctx
    localparam vec_t VEC [16] = '{
        '{4'd5, 19'h0,     1'b0, 1'b0, 8'h00, 1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0},
        '{4'd5, 19'h3,     1'b0, 1'b0, 8'h00, 1'b1, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0},
        '{4'd5, 19'h1,     1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1},
        '{4'd2, 19'h100,   1'b0, 1'b0, 8'h00, 1'b1, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0},
        '{4'd2, 19'h200,   1'b0, 1'b0, 8'h00, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0},
        '{4'd3, 19'h11,    1'b0, 1'b0, 8'h00, 1'b1, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0},
        '{4'd1, 19'h7,     1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0},
        '{4'd3, 19'h22,    1'b1, 1'b0, 8'h3C, 1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0},
        '{4'd3, 19'h22,    1'b1, 1'b0, 8'h3D, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1},
        '{4'd1, 19'h7,     1'b1, 1'b0, 8'h3C, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1},
        '{4'd3, 19'h22,    1'b0, 1'b0, 8'h00, 1'b1, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0},
        '{4'd6, 19'h41,    1'b1, 1'b0, 8'h10, 1'b1, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0},
        '{4'd6, 19'h40,    1'b1, 1'b0, 8'h10, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1},
        '{4'd5, 19'h0,     1'b0, 1'b1, 8'h00, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0},
        '{4'd5, 19'h80,    1'b0, 1'b0, 8'h00, 1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0},
        '{4'd5, 19'h2,     1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 2'd3, 1'b0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [BLK_W-1:0] req_block = '0;
    logic [IDX_W-1:0] req_index = '0;
    logic req_format = 1'b0;
    logic req_ignore = 1'b0;
    logic [LS_W-1:0] req_lserv = '0;
    logic [3:0] chip_id = 4'd5;
    logic [N-1:0] thread_en, ctx_phys_vld, ctx_pool_vld, ctx_os_vld, ctx_usr_vld;
    logic [N*ID_W-1:0] ctx_pool_cam, ctx_os_cam;
    logic [N*LS_W-1:0] ctx_usr_ls;
    logic done, match_valid, dup_error, unsupported_error, escalate;
    logic [TID_W-1:0] thread_id;
    logic [1:0] ring;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ipt_ctx_matcher #(.N_THREADS(N), .BLK_W(BLK_W), .IDX_W(IDX_W), .LS_W(LS_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_block(req_block), .req_index(req_index), .req_format(req_format),
        .req_ignore(req_ignore), .req_lserv(req_lserv), .chip_id(chip_id),
        .thread_en(thread_en), .ctx_phys_vld(ctx_phys_vld), .ctx_pool_vld(ctx_pool_vld),
        .ctx_pool_cam(ctx_pool_cam), .ctx_os_vld(ctx_os_vld), .ctx_os_cam(ctx_os_cam),
        .ctx_usr_vld(ctx_usr_vld), .ctx_usr_ls(ctx_usr_ls), .done(done),
        .match_valid(match_valid), .thread_id(thread_id), .ring(ring),
        .dup_error(dup_error), .unsupported_error(unsupported_error), .escalate(escalate)
    );

    function automatic logic [ID_W-1:0] tgt(input logic [3:0] b, input logic [18:0] i);
        return {b, i};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_thr(input int t, input logic pv, input logic plv, input logic [ID_W-1:0] pc,
                           input logic ov, input logic [ID_W-1:0] oc, input logic uv,
                           input logic [7:0] ul);
        ctx_phys_vld[t] = pv;
        ctx_pool_vld[t] = plv;
        ctx_pool_cam[t*ID_W +: ID_W] = pc;
        ctx_os_vld[t] = ov;
        ctx_os_cam[t*ID_W +: ID_W] = oc;
        ctx_usr_vld[t] = uv;
        ctx_usr_ls[t*LS_W +: LS_W] = ul;
    endtask

    task automatic init_ctx();
        thread_en = '1;
        set_thr(0, 1'b1, 1'b1, tgt(2, 19'h100), 1'b1, tgt(2, 19'h200), 1'b0, 8'h00);
        set_thr(1, 1'b0, 1'b1, tgt(3, 19'h11),  1'b1, tgt(3, 19'h22),  1'b1, 8'h3C);
        set_thr(2, 1'b1, 1'b0, tgt(3, 19'h11),  1'b1, tgt(1, 19'h7),   1'b0, 8'h3C);
        set_thr(3, 1'b1, 1'b1, tgt(6, 19'h40),  1'b1, tgt(6, 19'h41),  1'b1, 8'h10);
    endtask

    // issue one request; lat counts falling edges after acceptance until done
    task automatic run_req(input logic [3:0] b, input logic [18:0] i, input logic f,
                           input logic ig, input logic [7:0] ls, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_block = b; req_index = i;
        req_format = f; req_ignore = ig; req_lserv = ls;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!done && lat < N + 3) begin
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic logic [31:0] outcome();
        return {24'd0, match_valid, thread_id, ring, dup_error, unsupported_error, escalate};
    endfunction

    function automatic logic [31:0] expect_out(input logic mv, input logic [1:0] t,
                                               input logic [1:0] r, input logic d,
                                               input logic u, input logic e);
        return {24'd0, mv, t, r, d, u, e};
    endfunction

    initial begin : watchdog
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        int lat;
        init_ctx();
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 ready", 32'(req_ready), 32'd1);
        chk("R11 flags", {26'd0, done, match_valid, dup_error, unsupported_error, escalate, 1'b0}, 32'd0);
        rst_n = 1'b1;

        // table walk: R1 R2 R3 R4 R5 R7 R9
        for (int v = 0; v < 16; v++) begin
            run_req(VEC[v].blk, VEC[v].idx, VEC[v].fmt, VEC[v].ign, VEC[v].ls, lat);
            chk($sformatf("R9 latency vec%0d", v), 32'(lat), VEC[v].uns ? 32'd0 : 32'(N));
            chk($sformatf("R1 R2 R3 R4 R5 R7 result vec%0d", v), outcome(),
                expect_out(VEC[v].mv, VEC[v].tid, VEC[v].rng, VEC[v].dup, VEC[v].uns, VEC[v].esc));
            @(negedge clk);
            chk($sformatf("R9 done drops vec%0d", v), 32'(done), 32'd0);
        end

        // R3 ring priority inside one thread
        set_thr(0, 1'b1, 1'b1, tgt(5, 19'h0), 1'b1, tgt(5, 19'h0), 1'b0, 8'h00);
        run_req(4'd5, 19'h0, 1'b0, 1'b0, 8'h00, lat);
        chk("R3 phys first", outcome(), expect_out(1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0));
        ctx_phys_vld[0] = 1'b0;
        run_req(4'd5, 19'h0, 1'b0, 1'b0, 8'h00, lat);
        chk("R3 pool next", outcome(), expect_out(1'b1, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0));
        ctx_pool_vld[0] = 1'b0;
        run_req(4'd5, 19'h0, 1'b0, 1'b0, 8'h00, lat);
        chk("R3 os last", outcome(), expect_out(1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0));
        init_ctx();

        // R6 duplicate: thread 3 OS also holds target (2,0x200)
        ctx_os_cam[3*ID_W +: ID_W] = tgt(2, 19'h200);
        run_req(4'd2, 19'h200, 1'b0, 1'b0, 8'h00, lat);
        chk("R6 duplicate", {31'd0, dup_error}, 32'd1);
        chk("R6 no match no escalate", {30'd0, match_valid, escalate}, 32'd0);

        // R8 disabled thread 3 removes the duplicate
        thread_en[3] = 1'b0;
        run_req(4'd2, 19'h200, 1'b0, 1'b0, 8'h00, lat);
        chk("R8 skip dup partner", outcome(), expect_out(1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0));
        init_ctx();
        thread_en[0] = 1'b0;
        run_req(4'd5, 19'h0, 1'b0, 1'b0, 8'h00, lat);
        chk("R8 disabled thread escalates", outcome(), expect_out(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1));
        init_ctx();

        // R9 timing, busy ready, mid-scan request ignored
        @(negedge clk);
        req_valid = 1'b1; req_block = 4'd5; req_index = 19'h3;
        req_format = 1'b0; req_ignore = 1'b0; req_lserv = 8'h00;
        @(negedge clk);
        req_block = 4'd2; req_index = 19'h100;  // still valid while busy
        chk("R9 ready low while busy", 32'(req_ready), 32'd0);
        for (int k = 1; k < N; k++) begin
            @(negedge clk);
            if (k == N - 1) chk("R9 no early done", 32'(done), 32'd0);
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 done on due edge", 32'(done), 32'd1);
        chk("R9 busy request ignored", outcome(), expect_out(1'b1, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0));
        @(negedge clk);
        chk("R9 single cycle done", 32'(done), 32'd0);

        // R10 results hold while the context changes
        ctx_phys_vld = '0;
        ctx_os_vld = '0;
        thread_en = '0;
        repeat (5) @(negedge clk);
        chk("R10 hold", outcome(), expect_out(1'b1, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0));
        init_ctx();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule